// File: doc/BRIEF.md
# Memory Dependence Issue Scheduler

This block sits beside the load/store issue path of an out-of-order core. It decides when each in-flight memory operation may issue. Each operation is inserted with its sequence number, its PC, a store/load flag and a flag that says whether its source registers are already available. Unless the operation is non-speculative, an external predictor may also name a producing store by its sequence number. An operation becomes a candidate for issue once two conditions are met: its registers are available and its predicted store dependence is resolved. Of the candidates, the one with the smallest sequence number is offered on the issue port.

When a store issues, the operations that were linked to it are woken. Non-speculative operations ignore both conditions and wait for an explicit release. A squash with a sequence number removes every younger operation in one cycle. The predictor itself sits outside the block. The block reports three things to it: each inserted store, each issue, and each squash. It also passes ordering-violation reports from the load/store unit through to the predictor unchanged.

Top module: `mdq_sched`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) empties the block. While reset is held and after it, `iss_valid` is 0. `ins_full` is 0 while no insert asks for a store link.
- R2: An inserted operation has no memory dependence when `ins_pred_seq` is 0 or names no store currently held. Such an operation becomes an issue candidate in the next cycle if `ins_regs_rdy` is 1. If `ins_regs_rdy` is 0 it waits for registers only.
- R3: An inserted operation whose `ins_pred_seq` names a held store is linked to that store. It stays out of the candidates until that store issues, even if its registers are ready. A store that issues in the same cycle as the insert counts as not held.
- R4: A register-ready event (`rr_valid`, `rr_seq`) for a waiting operation makes it a candidate in the next cycle if its store dependence is resolved. Otherwise the block only records the event.
- R5: When a store issues, every operation linked to it has its dependence resolved. Those with ready registers become candidates in the next cycle. Issuing a load resolves nothing.
- R6: `iss_valid` flags that a candidate exists. `iss_seq`, `iss_pc` and `iss_store` describe the candidate with the smallest sequence number (unsigned, no wraparound). With `iss_take` high, that operation leaves the block at the clock edge. In the same cycle the block raises `pp_issue_valid` with the operation's sequence number, PC and store flag.
- R7: A non-speculative operation (`ins_nonspec` = 1) takes no store link and ignores register events. It becomes a candidate only in the cycle after a release (`rel_valid`) whose `rel_seq` matches it.
- R8: A squash (`sq_valid`, `sq_seq` = N) removes every held operation whose sequence number is greater than N, and their links go with them. In that cycle inserts, issues, register events and releases are all ignored. `pp_squash_valid`/`pp_squash_seq` repeat the squash in the same cycle.
- R9: Each accepted store insert raises `pp_store_valid` in its own cycle, carrying the store's sequence number and PC.
- R10: `ins_full` is 1 in two cases: all DEPTH slots are held, or a speculative insert would link to a store that already has MAX_DEP dependents. An insert presented while `ins_full` is 1 is refused and leaves no trace.
- R11: A violation report (`vio_valid`, load PC, store PC) appears unchanged on the `pp_vio_*` outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_pc | input | PC_W | PC of the inserted operation |
| ins_store | input | 1 | 1 = store, 0 = load |
| ins_regs_rdy | input | 1 | Source registers already available |
| ins_nonspec | input | 1 | Operation needs an explicit release |
| ins_pred_seq | input | SEQ_W | Predicted producing store, 0 = none |
| ins_full | output | 1 | Insert would be refused |
| rr_valid | input | 1 | Register-ready event |
| rr_seq | input | SEQ_W | Target of the register-ready event |
| rel_valid | input | 1 | Non-speculative release |
| rel_seq | input | SEQ_W | Target of the release |
| iss_valid | output | 1 | An issue candidate exists |
| iss_seq | output | SEQ_W | Candidate sequence number |
| iss_pc | output | PC_W | Candidate PC |
| iss_store | output | 1 | Candidate is a store |
| iss_take | input | 1 | Consume the candidate |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary, younger entries removed |
| vio_valid | input | 1 | Ordering violation report |
| vio_load_pc | input | PC_W | Violating load PC |
| vio_store_pc | input | PC_W | Conflicting store PC |
| pp_store_valid | output | 1 | Store inserted, to predictor |
| pp_store_seq | output | SEQ_W | Inserted store sequence number |
| pp_store_pc | output | PC_W | Inserted store PC |
| pp_issue_valid | output | 1 | Operation issued, to predictor |
| pp_issue_seq | output | SEQ_W | Issued sequence number |
| pp_issue_pc | output | PC_W | Issued PC |
| pp_issue_store | output | 1 | Issued operation is a store |
| pp_squash_valid | output | 1 | Squash forwarded to predictor |
| pp_squash_seq | output | SEQ_W | Forwarded squash boundary |
| pp_vio_valid | output | 1 | Violation forwarded |
| pp_vio_load_pc | output | PC_W | Forwarded load PC |
| pp_vio_store_pc | output | PC_W | Forwarded store PC |

## Verification
The candidate port and `ins_full` are combinational views of the slot table. A wrongly set ready, dependence or link bit therefore shows up as a wrong `iss_seq` or `iss_valid` in the very next cycle in which that operation would or would not be the oldest candidate. A stale link shows up later: a load stays invisible after its store has issued, or a store's dependent count is off and `ins_full` flips at the wrong fifth insert. The bench compares these ports, and the predictor-facing outputs, against a behavioural model on every cycle, so a divergence is caught at the first cycle it reaches a port.

// File: rtl/mdq_pkg.sv
package mdq_pkg;

  // Life cycle of one slot of the scheduler table.
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_READY = 2'd2
  } slot_st_e;

endpackage

// File: rtl/mdq_first_free.sv
module mdq_first_free #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest-numbered free slot wins; scan from the top so the last hit is lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mdq_oldest.sv
module mdq_oldest #(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][SEQ_W-1:0] seqs,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);

  logic [SEQ_W-1:0] best;

  // Linear minimum search over candidate slots (unsigned, no wraparound).
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || seqs[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = seqs[i];
      end
    end
  end

endmodule

// File: rtl/mdq_slot.sv
module mdq_slot
  import mdq_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_v,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic             wr_store,
  input  logic             wr_regs,
  input  logic             wr_memok,
  input  logic             wr_nonspec,
  input  logic             wr_linked,
  input  logic [IDX_W-1:0] wr_link,
  input  logic             pop_en,
  input  logic             wake_v,
  input  logic [IDX_W-1:0] wake_idx,
  input  logic             rr_v,
  input  logic [SEQ_W-1:0] rr_seq,
  input  logic             rel_v,
  input  logic [SEQ_W-1:0] rel_seq,
  output slot_st_e         st,
  output logic [SEQ_W-1:0] seq,
  output logic [PC_W-1:0]  pc,
  output logic             store,
  output logic             linked,
  output logic [IDX_W-1:0] link
);

  slot_st_e         st_q, st_n;
  logic             regs_q, regs_n;
  logic             mem_q, mem_n;
  logic             lnk_q, lnk_n;
  logic [SEQ_W-1:0] seq_q;
  logic [PC_W-1:0]  pc_q;
  logic             store_q;
  logic             ns_q;
  logic [IDX_W-1:0] link_q;
  logic             rr_hit, rel_hit, woke, young;

  assign rr_hit  = rr_v  && (rr_seq  == seq_q);
  assign rel_hit = rel_v && (rel_seq == seq_q);
  assign woke    = wake_v && lnk_q && (link_q == wake_idx);
  assign young   = (st_q != SLOT_FREE) && (seq_q > sq_seq);

  // Next-state process: squash first, then allocation, then issue / wake-up.
  always_comb begin
    st_n   = st_q;
    regs_n = regs_q;
    mem_n  = mem_q;
    lnk_n  = lnk_q;
    if (sq_v) begin
      if (young) begin
        st_n  = SLOT_FREE;
        lnk_n = 1'b0;
      end
    end else if (wr_en) begin
      regs_n = wr_regs;
      mem_n  = wr_memok;
      lnk_n  = wr_linked;
      st_n   = (wr_regs && wr_memok && !wr_nonspec) ? SLOT_READY : SLOT_WAIT;
    end else if (st_q == SLOT_READY) begin
      if (pop_en) st_n = SLOT_FREE;
    end else if (st_q == SLOT_WAIT) begin
      regs_n = regs_q | rr_hit;
      mem_n  = mem_q | woke;
      if (woke) lnk_n = 1'b0;
      if (ns_q) begin
        if (rel_hit) st_n = SLOT_READY;
      end else if (regs_n && mem_n) begin
        st_n = SLOT_READY;
      end
    end
  end

  // Control state register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_FREE;
      regs_q <= 1'b0;
      mem_q  <= 1'b0;
      lnk_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      regs_q <= regs_n;
      mem_q  <= mem_n;
      lnk_q  <= lnk_n;
    end
  end

  // Payload register, loaded only on allocation (no reset needed).
  always_ff @(posedge clk) begin
    if (wr_en && !sq_v) begin
      seq_q   <= wr_seq;
      pc_q    <= wr_pc;
      store_q <= wr_store;
      ns_q    <= wr_nonspec;
      link_q  <= wr_link;
    end
  end

  assign st     = st_q;
  assign seq    = seq_q;
  assign pc     = pc_q;
  assign store  = store_q;
  assign linked = lnk_q;
  assign link   = link_q;

  AST_NONSPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_WAIT && ns_q && !sq_v && !rel_hit) |=> (st_q != SLOT_READY)); // R7

  AST_SQUASH_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_v && young) |=> (st_q == SLOT_FREE)); // R8

endmodule

// File: rtl/mdq_sched.sv
module mdq_sched
  import mdq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MAX_DEP = 4,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic             ins_store,
  input  logic             ins_regs_rdy,
  input  logic             ins_nonspec,
  input  logic [SEQ_W-1:0] ins_pred_seq,
  output logic             ins_full,
  input  logic             rr_valid,
  input  logic [SEQ_W-1:0] rr_seq,
  input  logic             rel_valid,
  input  logic [SEQ_W-1:0] rel_seq,
  output logic             iss_valid,
  output logic [SEQ_W-1:0] iss_seq,
  output logic [PC_W-1:0]  iss_pc,
  output logic             iss_store,
  input  logic             iss_take,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             vio_valid,
  input  logic [PC_W-1:0]  vio_load_pc,
  input  logic [PC_W-1:0]  vio_store_pc,
  output logic             pp_store_valid,
  output logic [SEQ_W-1:0] pp_store_seq,
  output logic [PC_W-1:0]  pp_store_pc,
  output logic             pp_issue_valid,
  output logic [SEQ_W-1:0] pp_issue_seq,
  output logic [PC_W-1:0]  pp_issue_pc,
  output logic             pp_issue_store,
  output logic             pp_squash_valid,
  output logic [SEQ_W-1:0] pp_squash_seq,
  output logic             pp_vio_valid,
  output logic [PC_W-1:0]  pp_vio_load_pc,
  output logic [PC_W-1:0]  pp_vio_store_pc
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  slot_st_e                   s_st   [DEPTH];
  logic [IDX_W-1:0]           s_link [DEPTH];
  logic [DEPTH-1:0][SEQ_W-1:0] s_seq;
  logic [DEPTH-1:0][PC_W-1:0]  s_pc;
  logic [DEPTH-1:0]           s_store, s_linked, busy, rdy;

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] pick_idx;
  logic             iss_fire, wake_v, accept;
  logic             prod_hit, dep_need;
  logic [IDX_W-1:0] prod_idx;
  logic [CNT_W-1:0] dep_cnt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      busy[i] = (s_st[i] != SLOT_FREE);
      rdy[i]  = (s_st[i] == SLOT_READY);
    end
  end

  mdq_first_free #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
    .busy  (busy),
    .found (free_found),
    .idx   (free_idx)
  );

  mdq_oldest #(.N(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .cand  (rdy),
    .seqs  (s_seq),
    .found (iss_valid),
    .idx   (pick_idx)
  );

  assign iss_seq   = s_seq[pick_idx];
  assign iss_pc    = s_pc[pick_idx];
  assign iss_store = s_store[pick_idx];
  assign iss_fire  = iss_take && iss_valid && !sq_valid;
  assign wake_v    = iss_fire && s_store[pick_idx];

  // Producer lookup: a held store, not the one leaving this cycle.
  always_comb begin
    prod_hit = 1'b0;
    prod_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (busy[i] && s_store[i] && (s_seq[i] == ins_pred_seq) &&
          !(iss_fire && (pick_idx == IDX_W'(i)))) begin
        prod_hit = 1'b1;
        prod_idx = IDX_W'(i);
      end
    end
    if (ins_pred_seq == '0) prod_hit = 1'b0;
  end

  // Dependents already attached to the predicted producer.
  always_comb begin
    dep_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (s_linked[i] && (s_link[i] == prod_idx)) dep_cnt = dep_cnt + 1'b1;
    end
  end

  assign dep_need = prod_hit && !ins_nonspec;
  assign ins_full = !free_found || (dep_need && (dep_cnt >= CNT_W'(MAX_DEP)));
  assign accept   = ins_valid && !ins_full && !sq_valid;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    mdq_slot #(.SEQ_W(SEQ_W), .PC_W(PC_W), .IDX_W(IDX_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .sq_v       (sq_valid),
      .sq_seq     (sq_seq),
      .wr_en      (accept && (free_idx == IDX_W'(g))),
      .wr_seq     (ins_seq),
      .wr_pc      (ins_pc),
      .wr_store   (ins_store),
      .wr_regs    (ins_regs_rdy),
      .wr_memok   (!dep_need && !ins_nonspec),
      .wr_nonspec (ins_nonspec),
      .wr_linked  (dep_need),
      .wr_link    (prod_idx),
      .pop_en     (iss_fire && (pick_idx == IDX_W'(g))),
      .wake_v     (wake_v),
      .wake_idx   (pick_idx),
      .rr_v       (rr_valid),
      .rr_seq     (rr_seq),
      .rel_v      (rel_valid),
      .rel_seq    (rel_seq),
      .st         (s_st[g]),
      .seq        (s_seq[g]),
      .pc         (s_pc[g]),
      .store      (s_store[g]),
      .linked     (s_linked[g]),
      .link       (s_link[g])
    );

    AST_LINK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      s_linked[g] |-> (busy[s_link[g]] && s_store[s_link[g]])); // R3
  end

  // Predictor-facing notifications, same cycle as the event.
  assign pp_store_valid  = accept && ins_store;
  assign pp_store_seq    = ins_seq;
  assign pp_store_pc     = ins_pc;
  assign pp_issue_valid  = iss_fire;
  assign pp_issue_seq    = iss_seq;
  assign pp_issue_pc     = iss_pc;
  assign pp_issue_store  = iss_store;
  assign pp_squash_valid = sq_valid;
  assign pp_squash_seq   = sq_seq;
  assign pp_vio_valid    = vio_valid;
  assign pp_vio_load_pc  = vio_load_pc;
  assign pp_vio_store_pc = vio_store_pc;

  AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (s_st[pick_idx] == SLOT_READY)); // R6

  AST_POP_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> !busy[$past(pick_idx)]); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_full && !iss_fire && !sq_valid) |=>
      ($countones(busy) == $past($countones(busy)))); // R10

endmodule

// File: tb/tb_mdq_sched.sv
module tb_mdq_sched;

  localparam int DEPTH   = 16;
  localparam int MAX_DEP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 0, ins_store = 0, ins_regs_rdy = 0, ins_nonspec = 0;
  logic [15:0] ins_seq = 0, ins_pred_seq = 0;
  logic [31:0] ins_pc = 0;
  logic        rr_valid = 0, rel_valid = 0, iss_take = 0, sq_valid = 0, vio_valid = 0;
  logic [15:0] rr_seq = 0, rel_seq = 0, sq_seq = 0;
  logic [31:0] vio_load_pc = 0, vio_store_pc = 0;
  logic        ins_full, iss_valid, iss_store;
  logic [15:0] iss_seq, pp_store_seq, pp_issue_seq, pp_squash_seq;
  logic [31:0] iss_pc, pp_store_pc, pp_issue_pc, pp_vio_load_pc, pp_vio_store_pc;
  logic        pp_store_valid, pp_issue_valid, pp_issue_store, pp_squash_valid, pp_vio_valid;

  always #4 clk = ~clk;

  mdq_sched #(.DEPTH(DEPTH), .MAX_DEP(MAX_DEP), .SEQ_W(16), .PC_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_store(ins_store),
    .ins_regs_rdy(ins_regs_rdy), .ins_nonspec(ins_nonspec), .ins_pred_seq(ins_pred_seq),
    .ins_full(ins_full), .rr_valid(rr_valid), .rr_seq(rr_seq),
    .rel_valid(rel_valid), .rel_seq(rel_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_pc(iss_pc), .iss_store(iss_store),
    .iss_take(iss_take), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .vio_valid(vio_valid), .vio_load_pc(vio_load_pc), .vio_store_pc(vio_store_pc),
    .pp_store_valid(pp_store_valid), .pp_store_seq(pp_store_seq), .pp_store_pc(pp_store_pc),
    .pp_issue_valid(pp_issue_valid), .pp_issue_seq(pp_issue_seq), .pp_issue_pc(pp_issue_pc),
    .pp_issue_store(pp_issue_store), .pp_squash_valid(pp_squash_valid),
    .pp_squash_seq(pp_squash_seq), .pp_vio_valid(pp_vio_valid),
    .pp_vio_load_pc(pp_vio_load_pc), .pp_vio_store_pc(pp_vio_store_pc)
  );

  // Behavioural reference: a queue of held operations.
  typedef struct {
    int seq; bit st; int pc; bit rdy; bit regs; bit mem; bit ns; int link;
  } op_t;
  op_t   mq[$];
  int    n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  bit    done = 0;

  task automatic chk(string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  function automatic int oldest();
    int b = -1;
    foreach (mq[i]) if (mq[i].rdy && (b < 0 || mq[i].seq < mq[b].seq)) b = i;
    return b;
  endfunction

  function automatic int pop_idx();
    return (iss_take && !sq_valid) ? oldest() : -1;
  endfunction

  function automatic bit linked_hit();
    int pi = pop_idx();
    bit hit = 0;
    if (!ins_nonspec && ins_pred_seq != 0)
      foreach (mq[i]) if (i != pi && mq[i].st && mq[i].seq == int'(ins_pred_seq)) hit = 1;
    return hit;
  endfunction

  function automatic bit exp_full();
    int cnt = 0;
    bit hit = linked_hit();
    if (hit) foreach (mq[i]) if (mq[i].link == int'(ins_pred_seq)) cnt++;
    return (mq.size() >= DEPTH) || (hit && cnt >= MAX_DEP);
  endfunction

  task automatic compare();
    int  oi = oldest();
    bit  ef = exp_full();
    bit  ok = ins_valid && !ef && !sq_valid;
    chk("iss_valid", iss_valid, oi >= 0);
    if (oi >= 0) begin
      chk("iss_seq", iss_seq, mq[oi].seq);
      chk("iss_pc", iss_pc, mq[oi].pc);
      chk("iss_store", iss_store, mq[oi].st);
    end
    chk("ins_full", ins_full, ef);
    chk("pp_store_valid", pp_store_valid, ok && ins_store);
    if (ok && ins_store) begin
      chk("pp_store_seq", pp_store_seq, ins_seq);
      chk("pp_store_pc", pp_store_pc, ins_pc);
    end
    chk("pp_issue_valid", pp_issue_valid, pop_idx() >= 0);
    if (pop_idx() >= 0) begin
      chk("pp_issue_seq", pp_issue_seq, mq[oi].seq);
      chk("pp_issue_pc", pp_issue_pc, mq[oi].pc);
      chk("pp_issue_store", pp_issue_store, mq[oi].st);
    end
    chk("pp_squash_valid", pp_squash_valid, sq_valid);
    if (sq_valid) chk("pp_squash_seq", pp_squash_seq, sq_seq);
    chk("pp_vio_valid", pp_vio_valid, vio_valid);
    if (vio_valid) begin
      chk("pp_vio_load_pc", pp_vio_load_pc, vio_load_pc);
      chk("pp_vio_store_pc", pp_vio_store_pc, vio_store_pc);
    end
  endtask

  task automatic model_step();
    op_t keep[$];
    int  pi;
    bit  hit, ok;
    op_t n;
    if (sq_valid) begin
      foreach (mq[i]) if (mq[i].seq <= int'(sq_seq)) keep.push_back(mq[i]);
      mq = keep;
      return;
    end
    pi  = pop_idx();
    hit = linked_hit();
    ok  = ins_valid && !exp_full();
    foreach (mq[j]) begin
      if (j != pi && !mq[j].rdy) begin
        bit woke;
        if (rr_valid && int'(rr_seq) == mq[j].seq) mq[j].regs = 1;
        woke = (pi >= 0) && mq[pi].st && mq[j].link != 0 && mq[j].link == mq[pi].seq;
        if (woke) begin mq[j].mem = 1; mq[j].link = 0; end
        if (mq[j].ns) mq[j].rdy = rel_valid && int'(rel_seq) == mq[j].seq;
        else          mq[j].rdy = mq[j].regs && mq[j].mem;
      end
    end
    if (pi >= 0) mq.delete(pi);
    if (ok) begin
      n.seq = ins_seq; n.st = ins_store; n.pc = ins_pc; n.regs = ins_regs_rdy;
      n.ns = ins_nonspec; n.mem = !hit && !ins_nonspec; n.link = hit ? int'(ins_pred_seq) : 0;
      n.rdy = n.regs && n.mem && !n.ns;
      mq.push_back(n);
    end
  endtask

  task automatic tick();
    #1;
    compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0; rr_valid = 0; rel_valid = 0; iss_take = 0; sq_valid = 0; vio_valid = 0;
  endtask

  task automatic put(int seq, bit st, bit regs, int pred, bit ns);
    ins_valid = 1; ins_seq = 16'(seq); ins_pc = 32'(32'h1000 + seq * 4); ins_store = st;
    ins_regs_rdy = regs; ins_pred_seq = 16'(pred); ins_nonspec = ns;
  endtask

  task automatic squash(int n);
    sq_valid = 1; sq_seq = 16'(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int nseq;
    // R1: reset held low, then released away from the clock edge
    repeat (3) @(negedge clk);
    #1 chk("reset iss_valid", iss_valid, 0);
    chk("reset ins_full", ins_full, 0);
    rst_n = 1;
    @(negedge clk);
    tick();

    cur_tag = "R2";
    put(10, 0, 1, 0, 0); tick();
    put(11, 0, 0, 99, 0); tick();          // untracked producer
    tick();
    cur_tag = "R4";
    rr_valid = 1; rr_seq = 11; iss_take = 1; tick();
    iss_take = 1; tick();

    cur_tag = "R3";
    put(20, 1, 0, 0, 0); tick();
    put(21, 0, 1, 20, 0); tick();
    put(22, 0, 0, 20, 0); rr_valid = 1; rr_seq = 20; tick();
    tick();
    cur_tag = "R5";
    iss_take = 1; tick();                  // store issues, wakes 21 and 22
    put(23, 0, 1, 21, 0); iss_take = 1; tick();   // load as producer: no link
    rr_valid = 1; rr_seq = 22; iss_take = 1; tick();
    iss_take = 1; tick();
    tick();

    cur_tag = "R7";
    put(30, 0, 1, 0, 1); tick();
    rr_valid = 1; rr_seq = 30; tick();
    rel_valid = 1; rel_seq = 31; tick();
    rel_valid = 1; rel_seq = 30; tick();
    iss_take = 1; tick();

    cur_tag = "R8";
    put(40, 0, 1, 0, 0); tick();
    put(41, 1, 1, 0, 0); tick();
    put(42, 0, 0, 41, 0); tick();
    put(43, 0, 1, 0, 0); iss_take = 1; rr_valid = 1; rr_seq = 42; squash(40); tick();
    tick();
    iss_take = 1; tick();

    cur_tag = "R10";
    for (int k = 0; k < DEPTH; k++) begin put(50 + k, 0, 0, 0, 0); tick(); end
    put(66, 1, 1, 0, 0); tick();            // refused: table full
    tick();
    squash(1); tick();
    put(70, 1, 0, 0, 0); tick();
    for (int k = 1; k <= MAX_DEP; k++) begin put(70 + k, 0, 1, 70, 0); tick(); end
    put(75, 1, 1, 70, 0); tick();           // refused: dependent limit
    put(76, 0, 1, 70, 1); tick();           // non-speculative: no link, accepted
    squash(1); tick();

    cur_tag = "R9";
    put(80, 1, 1, 0, 0); tick();
    put(81, 1, 0, 80, 1); tick();
    cur_tag = "R11";
    vio_valid = 1; vio_load_pc = 32'hDEAD_0004; vio_store_pc = 32'h0BEE_F008; tick();
    squash(1); tick();

    // R6 and all others: randomized traffic against the model
    cur_tag = "R6";
    nseq = 100;
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 99);
      int pred = 0;
      int sqn = 0;
      if ($urandom_range(0, 99) < 70) begin
        if (mq.size() > 0 && $urandom_range(0, 1) == 1) pred = mq[$urandom_range(0, mq.size() - 1)].seq;
        else if ($urandom_range(0, 3) == 0) pred = 5000;
        put(nseq, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, pred,
            $urandom_range(0, 9) == 0);
        nseq++;
      end
      if (mq.size() > 0 && $urandom_range(0, 1) == 1) begin
        rr_valid = 1; rr_seq = 16'(mq[$urandom_range(0, mq.size() - 1)].seq);
      end
      if (mq.size() > 0 && $urandom_range(0, 3) == 0) begin
        rel_valid = 1; rel_seq = 16'(mq[$urandom_range(0, mq.size() - 1)].seq);
      end
      iss_take = ($urandom_range(0, 99) < 55);
      if (r < 3) begin
        sqn = nseq - $urandom_range(1, 6);
        if (sqn < 1) sqn = 1;
        squash(sqn);
      end
      if (r > 96) begin vio_valid = 1; vio_load_pc = $urandom; vio_store_pc = $urandom; end
      tick();
      if (r < 3) nseq = sqn + 1;
    end

    // R1: asynchronous reset while entries are held
    cur_tag = "R1";
    put(9000, 0, 1, 0, 0); tick();
    #3 rst_n = 0;
    #1 chk("async reset iss_valid", iss_valid, 0);
    chk("async reset ins_full", ins_full, 0);
    mq.delete();
    @(negedge clk);
    rst_n = 1;
    tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule